// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat memory burst. A burst begins when either of two address-strobe inputs is sampled high on a rising clock edge. The external address is then captured as the starting address. After that, the sequencer produces each later address itself, one beat for every cycle in which the advance input is high.

The upper address bits stay fixed from the load until the next strobe. Only the low counter bits move, and they follow one of two orders chosen by a static order-select input. In linear order the beat count is added to the starting low bits, modulo the burst length. In interleaved order the beat count is XORed into them. When the fourth beat has been stepped past, the address returns to the starting word and a one-cycle wrap pulse is raised.

All outputs come from registers through combinational order logic. An action taken at a clock edge is therefore visible on the outputs directly after that edge.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the starting address and the beat count are cleared. As a result, `addr_out` is 0 and `wrap_pulse` is 0 after that edge.
- R2: When `strobe_proc` is sampled high, `addr_out` equals the `addr_in` value sampled at that edge, from that edge onwards (beat 0).
- R3: When `strobe_ctrl` is sampled high, the load behaves exactly as in R2. Either strobe alone, or both together, starts a burst.
- R4: With no strobe and `advance` high, the beat count steps by one. With no strobe and `advance` low, `addr_out` keeps its value as long as `order_sel` is unchanged.
- R5: With `order_sel` = 0 (linear), the low 2 bits of `addr_out` equal (start low bits + beat) mod 4.
- R6: With `order_sel` = 1 (interleaved), the low 2 bits of `addr_out` equal start low bits XOR beat.
- R7: Bits above bit 1 of `addr_out` equal the starting address's upper bits in every cycle until the next strobe.
- R8: A strobe sampled together with `advance` reloads the address and does not step the beat count.
- R9: Advancing from beat 3 returns `addr_out` to the starting address. `wrap_pulse` is then high for exactly the one cycle after that edge, and is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_proc | input | 1 | First burst-start strobe, loads `addr_in` |
| strobe_ctrl | input | 1 | Second burst-start strobe, loads `addr_in` |
| advance | input | 1 | Step to the next beat when no strobe is present |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current internal burst address |
| wrap_pulse | output | 1 | One-cycle flag after the burst returns to its start |

## Verification
The bench builds the block with `ADDR_W` = 10 and `CNT_W` = 2. The narrower address keeps the chosen starting addresses readable, while the upper-bit hold is still checked across eight bits above the counter. With a 2-bit count, every starting low value can be walked through a full wrap in both orders. The stimulus also covers the case of a strobe arriving together with `advance`, and a reload in the middle of a burst.

// File: rtl/bseq_pkg.sv
// Package: shared types for the burst address sequencer.
// Assumes: nothing beyond a single clock domain.
package bseq_pkg;

    // Beat ordering selected by the static order input.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

endpackage

// File: rtl/bseq_beat_ctr.sv
// Module: beat counter with wrap pulse.
// Counts burst beats. Clears on load, steps on step_en. Raises
// wrap_o for one cycle after stepping past the last beat.
// Assumes: load and step_en are never both high; the caller
// gives load priority.
module bseq_beat_ctr #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step_en,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    localparam logic [CNT_W-1:0] LAST_BEAT = {CNT_W{1'b1}};

    // Beat count and wrap flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o  <= '0;
            wrap_o <= 1'b0;
        end else if (load) begin
            cnt_o  <= '0;
            wrap_o <= 1'b0;
        end else if (step_en) begin
            cnt_o  <= cnt_o + 1'b1;
            wrap_o <= (cnt_o == LAST_BEAT);
        end else begin
            wrap_o <= 1'b0;
        end
    end

    // R9: the wrap flag only appears when the count is back at beat 0.
    p_wrap_at_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> (cnt_o == '0));

    // R9: the wrap flag never lasts for two cycles in a row.
    p_wrap_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> !wrap_o);

endmodule

// File: rtl/bseq_addr_hold.sv
// Module: starting-address register.
// Captures the full external address on load and holds it until
// the next load.
// Assumes: reset clears it to zero.
module bseq_addr_hold #(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] start_o
);

    // Holding register for the burst's starting address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_o <= '0;
        else if (load)
            start_o <= addr_i;
    end

    // R7: with no load, the stored address never changes.
    p_start_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(start_o));

endmodule

// File: rtl/bseq_order_map.sv
// Module: beat-to-low-address mapping.
// Combines the starting low bits with the beat count, using either
// a modular add or an XOR.
// Assumes: purely combinational; order may change at any time.
module bseq_order_map #(
    parameter int CNT_W = 2
) (
    input  bseq_pkg::order_e  order_i,
    input  logic [CNT_W-1:0]  start_lo_i,
    input  logic [CNT_W-1:0]  beat_i,
    output logic [CNT_W-1:0]  lo_o
);
    import bseq_pkg::*;

    // Selects the low address bits for the current beat.
    always_comb begin
        unique case (order_i)
            ORD_XOR:    lo_o = start_lo_i ^ beat_i;
            default:    lo_o = start_lo_i + beat_i;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst address sequencer (top).
// Loads a starting address on either strobe. Then steps the low CNT_W
// bits through a linear or interleaved order on advance, and flags
// the return to the start after the last beat.
// Assumes: order_sel is static during a burst; a strobe overrides
// advance.
module burst_addr_seq #(
    parameter int ADDR_W = 18,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_proc,
    input  logic              strobe_ctrl,
    input  logic              advance,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              wrap_pulse
);
    import bseq_pkg::*;

    localparam int UP_W = ADDR_W - CNT_W;

    logic              any_strobe;
    logic              step_en;
    logic [ADDR_W-1:0] start_q;
    logic [CNT_W-1:0]  beat_q;
    logic [CNT_W-1:0]  lo_bits;
    order_e            order_mode;

    // Strobe priority: a load suppresses the step.
    always_comb begin
        any_strobe = strobe_proc | strobe_ctrl;
        step_en    = advance & ~any_strobe;
        order_mode = order_e'(order_sel);
    end

    bseq_addr_hold #(.ADDR_W(ADDR_W)) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (any_strobe),
        .addr_i  (addr_in),
        .start_o (start_q)
    );

    bseq_beat_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (any_strobe),
        .step_en (step_en),
        .cnt_o   (beat_q),
        .wrap_o  (wrap_pulse)
    );

    bseq_order_map #(.CNT_W(CNT_W)) i_map (
        .order_i    (order_mode),
        .start_lo_i (start_q[CNT_W-1:0]),
        .beat_i     (beat_q),
        .lo_o       (lo_bits)
    );

    // Output address: held upper bits over the ordered low bits.
    always_comb begin
        addr_out = {start_q[ADDR_W-1:CNT_W], lo_bits};
    end

    // R2 R3 R8: any strobe makes the sampled address appear at once.
    p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> (addr_out == $past(addr_in)));

    // R4: an idle cycle with an unchanged order keeps the address.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_strobe && !advance) |=>
            ((order_sel != $past(order_sel)) || (addr_out == $past(addr_out))));

    // R7: the upper bits move only on a strobe.
    p_upper_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !any_strobe |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W])));

    // R9: on a wrap, the output is back at the stored start.
    p_wrap_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> (addr_out == start_q));

    initial begin
        a_width_r7: assert (UP_W >= 1);
    end

endmodule

// File: tb/test_burst_addr_seq.sv
// Bench: behavioural reference model compared on every clock.
module test_burst_addr_seq;

    localparam int  AW     = 10;
    localparam int  CW     = 2;
    localparam time T_CLK  = 10ns;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sp, sc, adv, mode;
    logic [AW-1:0] ain;
    logic [AW-1:0] aout;
    logic          wrap;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int m_start = 0;
    int m_beat  = 0;
    int m_wrap  = 0;

    always #(T_CLK/2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) i_burst_addr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .strobe_proc (sp),
        .strobe_ctrl (sc),
        .advance     (adv),
        .order_sel   (mode),
        .addr_in     (ain),
        .addr_out    (aout),
        .wrap_pulse  (wrap)
    );

    function automatic int expect_addr();
        int lo;
        if (mode) lo = (m_start % 4) ^ m_beat;
        else      lo = ((m_start % 4) + m_beat) % 4;
        return (m_start / 4) * 4 + lo;
    endfunction

    // One clock: drive, let the edge happen, update the model, compare at negedge.
    task automatic cyc(input logic r, input logic p, input logic c, input logic a,
                       input logic m, input int addr, input string tag);
        rst_n = r; sp = p; sc = c; adv = a; mode = m; ain = AW'(addr);
        @(posedge clk);
        if (!r) begin
            m_start = 0; m_beat = 0; m_wrap = 0;
        end else if (p || c) begin
            m_start = addr; m_beat = 0; m_wrap = 0;
        end else if (a) begin
            m_wrap = (m_beat == 3) ? 1 : 0;
            m_beat = (m_beat + 1) % 4;
        end else begin
            m_wrap = 0;
        end
        @(negedge clk);
        checks++;
        if (int'(aout) != expect_addr()) begin
            errors++;
            $display("FAIL %s addr_out actual=%0h expected=%0h", tag, aout, expect_addr());
        end
        checks++;
        if (int'(wrap) != m_wrap) begin
            errors++;
            $display("FAIL %s wrap_pulse actual=%0d expected=%0d", tag, wrap, m_wrap);
        end
    endtask

    initial begin
        #(T_CLK * 5000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sp = 0; sc = 0; adv = 0; mode = 0; ain = '0;
        @(negedge clk);
        // R1: reset state, also with advance toggling
        cyc(0, 0, 0, 0, 0, 'h155, "R1");
        cyc(0, 0, 0, 1, 0, 'h2AA, "R1");
        cyc(0, 0, 0, 0, 0, 0, "R1");
        // R2 R5 R4 R9: linear burst with idle gaps
        cyc(1, 1, 0, 0, 0, 'h2B6, "R2");
        cyc(1, 0, 0, 1, 0, 0, "R5");
        cyc(1, 0, 0, 0, 0, 'h3FF, "R4");
        cyc(1, 0, 0, 1, 0, 0, "R5");
        cyc(1, 0, 0, 1, 0, 0, "R5");
        cyc(1, 0, 0, 1, 0, 0, "R9");
        cyc(1, 0, 0, 0, 0, 0, "R9");
        // R3 R6 R9: interleaved burst from second strobe
        cyc(1, 0, 1, 0, 1, 'h1C9, "R3");
        for (int k = 0; k < 5; k++) cyc(1, 0, 0, 1, 1, 'h3FF, "R6");
        // R8: strobe with advance reloads without stepping
        cyc(1, 1, 0, 1, 0, 'h0F2, "R8");
        cyc(1, 0, 0, 1, 0, 0, "R5");
        cyc(1, 0, 1, 1, 0, 'h343, "R8");
        cyc(1, 1, 1, 0, 0, 'h17D, "R3");
        cyc(1, 0, 0, 1, 0, 0, "R7");
        // R7: mid-burst reload switches upper bits; then hold through wrap
        cyc(1, 0, 1, 0, 0, 'h282, "R7");
        for (int k = 0; k < 5; k++) cyc(1, 0, 0, 1, 0, 'h0, "R7");
        // R5 R6 R9: every start low value in both orders
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                cyc(1, s[0], ~s[0], 0, m[0], 'h1A0 + s + 16 * m, "R2");
                for (int k = 0; k < 5; k++)
                    cyc(1, 0, 0, 1, m[0], 0, m ? "R6" : "R5");
            end
        end
        // R1: reset in mid-burst
        cyc(1, 1, 0, 0, 1, 'h3A7, "R2");
        cyc(1, 0, 0, 1, 1, 0, "R6");
        cyc(0, 0, 0, 1, 1, 0, "R1");
        cyc(1, 0, 0, 0, 0, 0, "R4");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule